// File: doc/BRIEF.md
# Double to single precision narrower

This block narrows a 64-bit double-precision value into a 32-bit single-precision word. A value is offered on `din_i` while `start_i` is high. In the cycle that start is accepted the block sorts the value into one of three bands by its biased exponent. The first band covers large magnitudes and signed zeros: the result is a direct bit-slice copy. The second band covers magnitudes that only fit a single as a denormal: the result comes from an iterative right-shift that runs one bit per cycle. Everything else gives an all-zero word.

The result word is registered. It is marked by a one-cycle `done_o` pulse and is held until the next result is produced. No rounding is done; fraction bits that do not fit are dropped. While a denormalization is running, further start requests are dropped, so callers wait for `done_o` before offering the next value.

Top module: `d2s_narrow`

## Requirements
- R1: While reset is high and after it is released, with no start given, `word_o` is zero and `done_o` is low.
- R2: When the biased exponent `din_i[62:52]` is above 896, the result is `{din_i[63:62], din_i[58:29]}`.
- R3: When `din_i[62:0]` is all zero (a signed zero), the result is `{din_i[63:62], din_i[58:29]}`, which is the sign in bit 31 followed by zeros.
- R4: When the biased exponent is in 874..896 and the magnitude is nonzero, let F = `{1'b1, din_i[51:0]} >> (897 - exponent)` (53 bits). The result is then `{din_i[63], 8'h00, F[51:29]}`.
- R5: When the magnitude is nonzero and the biased exponent is below 874 (this includes exponent 0), the result is 32'h0.
- R6: The input fraction bits that do not fit in the result never change it. There is no rounding: for example, 64'h3FF0_0000_1FFF_FFFF gives 32'h3F80_0000.
- R7: `done_o` goes high in the first cycle after the start edge for the copy and zero bands. For the denormal band it goes high 898 - exponent cycles after that edge.
- R8: `done_o` is high for exactly one cycle per conversion, and `word_o` changes only in a cycle where `done_o` is high.
- R9: A start request made while a denormalization is running is ignored. The running conversion's result and timing are unchanged, and no extra `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion of `din_i` |
| din_i | input | 64 | Double-precision source value, bit 63 = sign |
| word_o | output | 32 | Single-precision result, held between conversions |
| done_o | output | 1 | One-cycle pulse marking a new `word_o` |

## Verification
The assertions assume only that reset is high before the first clock edge. They place no limit on `din_i` or `start_i`, because every 64-bit pattern falls into one of the three bands and start may arrive at any time. The property on the shift load relies on the classifier giving a remaining count of 0..22 for every denormal-band value. The stimulus covers this by drawing exponents from each band: above the copy threshold, inside the denormal window, below it, zero exponent with a nonzero fraction, and a zero magnitude. It also raises start during a running shift so that the ignore path and the step-count property are both exercised.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
  localparam int DBL_W   = 64;
  localparam int DEXP_W  = 11;
  localparam int DFRAC_W = 52;
  localparam int DBIAS   = 1023;
  localparam int SGL_W   = 32;
  localparam int SEXP_W  = 8;
  localparam int SFRAC_W = 23;
  localparam int SBIAS   = 127;
  // biased double exponent bounds of the denormal window
  localparam int DEN_HI  = DBIAS - SBIAS;
  localparam int DEN_LO  = DEN_HI - SFRAC_W + 1;
  // remaining shifts after the load step, 0..SFRAC_W-1
  localparam int CNT_W   = $clog2(SFRAC_W);
  // top bit of the fraction slice kept by the copy band
  localparam int COPY_HI = DBL_W - 3 - (DEXP_W - SEXP_W);

  typedef enum logic [1:0] {K_ZERO, K_COPY, K_DENORM} kind_t;
endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
  import d2s_pkg::*;
(
  input  logic [DBL_W-1:0] val_i,
  output kind_t            kind_o,
  output logic [CNT_W-1:0] rem_o,
  output logic [SGL_W-1:0] copy_o
);
  logic [DEXP_W-1:0] bexp;
  logic              mag_zero;

  always_comb begin
    bexp     = val_i[DBL_W-2 -: DEXP_W];
    mag_zero = (val_i[DBL_W-2:0] == '0);
    if (mag_zero || (bexp > DEXP_W'(DEN_HI)))
      kind_o = K_COPY;
    else if (bexp >= DEXP_W'(DEN_LO))
      kind_o = K_DENORM;
    else
      kind_o = K_ZERO;
    // shifts still owed after the pre-shifted load (modular, valid in window)
    rem_o  = CNT_W'(DEN_HI) - bexp[CNT_W-1:0];
    copy_o = {val_i[DBL_W-1 -: 2], val_i[COPY_HI -: SGL_W-2]};
  end
endmodule

// File: rtl/d2s_shift.sv
module d2s_shift
  import d2s_pkg::*;
#(
  parameter int FW = SFRAC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [FW-1:0] frac_i,
  input  logic [CW-1:0] rem_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [FW-1:0] frac_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] frac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= rem_i;
      frac_q <= frac_i;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        frac_q <= {1'b0, frac_q[FW-1:1]};
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
  assign frac_o = frac_q;

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (rem_i < CW'(FW) && frac_i[FW-1])); // R4
endmodule

// File: rtl/d2s_pack.sv
module d2s_pack
  import d2s_pkg::*;
(
  input  kind_t              sel_i,
  input  logic [SGL_W-1:0]   copy_i,
  input  logic               sign_i,
  input  logic [SFRAC_W-1:0] frac_i,
  output logic [SGL_W-1:0]   word_o
);
  always_comb begin
    case (sel_i)
      K_COPY:   word_o = copy_i;
      K_DENORM: word_o = {sign_i, {SEXP_W{1'b0}}, frac_i};
      default:  word_o = '0;
    endcase
  end
endmodule

// File: rtl/d2s_narrow.sv
module d2s_narrow
  import d2s_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [63:0] din_i,
  output logic [31:0] word_o,
  output logic        done_o
);
  kind_t              kind;
  kind_t              sel;
  logic [CNT_W-1:0]   rem;
  logic [SGL_W-1:0]   copy_w;
  logic [SGL_W-1:0]   packed_w;
  logic               sh_busy, sh_last, sh_load, accept, finish;
  logic [SFRAC_W-1:0] sh_frac;
  logic               sign_q;

  d2s_classify u_cls (
    .val_i  (din_i),
    .kind_o (kind),
    .rem_o  (rem),
    .copy_o (copy_w)
  );

  assign accept  = start_i && !sh_busy;
  assign sh_load = accept && (kind == K_DENORM);
  assign finish  = sh_last || (accept && (kind != K_DENORM));
  assign sel     = sh_last ? K_DENORM : kind;

  // load already shifted by one: implicit one plus the top fraction bits
  d2s_shift #(.FW(SFRAC_W), .CW(CNT_W)) u_sh (
    .clk    (clk),
    .rst    (rst),
    .load_i (sh_load),
    .frac_i ({1'b1, din_i[DFRAC_W-1 -: SFRAC_W-1]}),
    .rem_i  (rem),
    .busy_o (sh_busy),
    .last_o (sh_last),
    .frac_o (sh_frac)
  );

  d2s_pack u_pack (
    .sel_i  (sel),
    .copy_i (copy_w),
    .sign_i (sign_q),
    .frac_i (sh_frac),
    .word_o (packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (sh_load) sign_q <= din_i[DBL_W-1];
      if (finish)  word_o <= packed_w;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(word_o)); // R8
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    sh_last |=> done_o); // R7
  AST_DENORM_EXP: assert property (@(posedge clk) disable iff (rst)
    sh_last |=> (word_o[SGL_W-2 -: SEXP_W] == '0)); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (sh_busy && !sh_last) |=> !done_o); // R9
endmodule

// File: tb/tb_d2s_narrow.sv
`timescale 1ns/1ps
module tb_d2s_narrow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] din = '0;
  logic [31:0] word;
  logic        done;
  int n_tot = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  d2s_narrow dut (
    .clk(clk), .rst(rst), .start_i(start), .din_i(din),
    .word_o(word), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [63:0] d);
    int e;
    logic [52:0] f;
    e = int'(d[62:52]);
    if (e > 896 || d[62:0] == '0) return {d[63:62], d[58:29]};
    if (e >= 874) begin
      f = {1'b1, d[51:0]} >> (897 - e);
      return {d[63], 8'h00, f[51:29]};
    end
    return 32'h0;
  endfunction

  function automatic int ref_lat(input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    if (d[62:0] != '0 && e >= 874 && e <= 896) return 898 - e;
    return 1;
  endfunction

  function automatic string req_of(input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    if (d[62:0] == '0) return "R3";
    if (e > 896) return "R2";
    if (e >= 874) return "R4";
    return "R5";
  endfunction

  task automatic convert(input logic [63:0] d, input string req);
    logic [31:0] expw;
    int lat;
    expw = ref_word(d);
    @(negedge clk); start = 1'b1; din = d;
    @(negedge clk); start = 1'b0; din = {$urandom, $urandom};
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk); lat++;
    end
    chk(done && word == expw, req, 64'(word), 64'(expw));
    chk(lat == ref_lat(d), "R7 latency", 64'(lat), 64'(ref_lat(d)));
    @(negedge clk);
    chk(!done && word == expw, "R8 pulse/hold", {31'b0, done, word}, 64'(expw));
  endtask

  initial begin
    #(200000 * 4);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] expw;
    int lat;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(word == 0 && !done, "R1 in reset", {31'b0, done, word}, 64'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(word == 0 && !done, "R1 after reset", {31'b0, done, word}, 64'h0);

    convert(64'h3FF0_0000_0000_0000, "R2 one");
    convert(64'hC004_0000_0000_0000, "R2 neg");
    convert(64'h3810_0000_0000_0000, "R2 exp897");
    convert(64'h7FF8_0000_0000_0001, "R2 nan");
    convert(64'h0000_0000_0000_0000, "R3 pos zero");
    convert(64'h8000_0000_0000_0000, "R3 neg zero");
    convert(64'h3800_0000_0000_0000, "R4 exp896");
    convert(64'hB7FF_FFFF_FFFF_FFFF, "R4 neg exp895");
    convert(64'h36A0_0000_0000_0000, "R4 exp874");
    convert(64'h3690_0000_0000_0000, "R5 exp873");
    convert(64'h0000_0000_0000_0001, "R5 exp0");
    convert(64'h3FF0_0000_1FFF_FFFF, "R6 trunc copy");
    convert(64'h37F0_0000_0FFF_FFFF, "R6 trunc denorm");

    // R9: start during a long shift is dropped
    expw = ref_word(64'h36AA_BCDE_F012_3456);
    @(negedge clk); start = 1'b1; din = 64'h36AA_BCDE_F012_3456;
    @(negedge clk); start = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; din = 64'h4000_0000_0000_0000;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk(done && word == expw, "R9 result", 64'(word), 64'(expw));
    chk(lat == 24, "R9 latency", 64'(lat), 64'd24);
    lat = 0;
    repeat (30) begin @(negedge clk); if (done) lat++; end
    chk(lat == 0 && word == expw, "R9 no extra done", 64'(lat), 64'h0);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      int cat;
      int e;
      d = {$urandom, $urandom};
      cat = int'($urandom_range(0, 4));
      case (cat)
        0: e = int'($urandom_range(897, 2047));
        1: e = int'($urandom_range(874, 896));
        2: e = int'($urandom_range(1, 873));
        default: e = 0;
      endcase
      d[62:52] = 11'(e);
      if (cat == 4) d[62:0] = '0;
      convert(d, req_of(d));
    end

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule